// File: doc/BRIEF.md
# PCM Highway Time-Slot Transmitter

This block places one voice sample per frame onto a shared serial PCM bus that several devices use in turn. A frame sync pulse marks the start of each frame on the bit clock; after a programmed number of bit clocks the block shifts its sample out, most significant bit first. While it does so it raises a slot strobe. Outside its slot it releases the bus so that other devices can drive their own slots.

The sample is either an already compressed 8-bit code or a 16-bit linear word, and a format input picks which, setting the slot length. A law-select input only labels the 8-bit code as one of the two common companding laws. It is carried to a status output together with the sample. An adjacent-slot mode releases the data line halfway through the last bit, so that a device owning the next slot can start without overlap.

Nothing is driven until the transmit enable is set, which software does once the slot position and format are written. High impedance is expressed as output enables toward the pad ring (`dx_oe`, `tsc_oe`). The bit clock and frame sync are assumed synchronous to `clk` and several `clk` periods long. Each is seen one `clk` edge after it changes.

Top module: `pcm_slot_tx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `dx_oe`, `tsc` and `tsc_oe` are 0.
- R2: `tsc_oe` takes the value of `tx_en` sampled at each bit-clock rising edge. While `tsc_oe` is 0, `dx_oe` and `tsc` are 0.
- R3: With `adj_mode` = 0, `dx_oe` is 1 for both halves of every bit of the slot and rises only right after a bit-clock rising edge.
- R4: With `adj_mode` = 1, `dx_oe` drops right after the bit-clock falling edge inside the last bit of the slot. All earlier bits of that slot are driven for their full period.
- R5: `lin_mode` = 0 sends `sample_in[7:0]` as an 8-bit slot, and `lin_mode` = 1 sends `sample_in[15:0]` as a 16-bit slot. `tsc` is 1 for exactly the slot length in bit periods.
- R6: `law_flag` shows `law_sel` as it was captured at the last frame sync. Later changes of `law_sel` have no effect until the next frame sync.
- R7: Bits leave MSB first. `dx` changes only right after a bit-clock rising edge.
- R8: A frame starts at the bit-clock rising edge where `fsync` is seen high after having been low at the previous rising edge. The sample is captured at that edge. The first slot bit is launched `slot_start` rising edges later, and on that same edge when `slot_start` = 0.
- R9: If `tx_en` is seen low at a rising edge during a slot, `dx_oe`, `tsc` and `tsc_oe` go to 0 right after that edge, and the rest of that slot is not sent.
- R10: No slot is sent before the first frame sync after reset, even with `tx_en` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | PCM bit clock, synchronous to clk |
| fsync | input | 1 | Frame sync, sampled on bit-clock rising edges |
| sample_in | input | 16 | Sample word; the low 8 bits in compressed format |
| slot_start | input | 8 | Bit clocks from frame sync to the first slot bit |
| tx_en | input | 1 | Transmit enable |
| lin_mode | input | 1 | 0 = 8-bit compressed, 1 = 16-bit linear |
| adj_mode | input | 1 | 1 = release the data line in the second half of the last bit |
| law_sel | input | 1 | Companding law label: 0 = A-law, 1 = mu-law |
| dx | output | 1 | Serial data toward the pad |
| dx_oe | output | 1 | Drive enable for dx |
| tsc | output | 1 | Slot strobe, high during the slot |
| tsc_oe | output | 1 | Drive enable for the slot strobe |
| law_flag | output | 1 | Law label of the sample in flight |

## Verification
Every output changes on the first `clk` edge after the block sees a bit-clock edge. Data, strobe and enables move on the rising edge, and the adjacent-mode release moves on the falling edge. The bench drives each bit-clock edge on a falling `clk` edge and waits two `clk` periods before it samples, so it reads the middle of each half-bit, where no update can be in progress. A scoreboard queue holds the expected first-half and second-half values for every bit of a frame, computed from the slot position, format, enable and adjacent-mode settings.

// File: rtl/pcm_slot_tx_pkg.sv
package pcm_slot_tx_pkg;

    localparam int COMP_W = 8;
    localparam int LIN_W  = 16;
    localparam int LEN_W  = $clog2(LIN_W + 1);

    typedef enum logic {
        FMT_COMP = 1'b0,
        FMT_LIN  = 1'b1
    } fmt_e;

    typedef struct packed {
        logic [LIN_W-1:0] word;
        fmt_e             fmt;
        logic             adj;
    } slot_ctx_t;

    // Number of bit periods the slot lasts for a given format
    function automatic logic [LEN_W-1:0] slot_len(input fmt_e f);
        return (f == FMT_LIN) ? LEN_W'(LIN_W) : LEN_W'(COMP_W);
    endfunction

    // Left-align the word so the first bit to send sits in the top position
    function automatic logic [LIN_W-1:0] align_word(input logic [LIN_W-1:0] w, input fmt_e f);
        return (f == FMT_LIN) ? w : {w[COMP_W-1:0], {(LIN_W-COMP_W){1'b0}}};
    endfunction

endpackage

// File: rtl/pcm_bclk_edge.sv
module pcm_bclk_edge (
    input  logic clk,
    input  logic rst,
    input  logic bclk,
    input  logic fsync,
    output logic bit_rise,
    output logic bit_fall,
    output logic frame_mark
);
    logic bclk_q;
    logic fs_q;

    assign bit_rise   = bclk & ~bclk_q;
    assign bit_fall   = ~bclk & bclk_q;
    assign frame_mark = bit_rise & fsync & ~fs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q <= 1'b0;
            fs_q   <= 1'b0;
        end else begin
            bclk_q <= bclk;
            if (bit_rise) begin
                fs_q <= fsync;
            end
        end
    end
endmodule

// File: rtl/pcm_frame_pos.sv
module pcm_frame_pos #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_rise,
    input  logic             frame_mark,
    input  logic [CNT_W-1:0] slot_start,
    output logic             launch
);
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] pos_nx;
    logic             synced;
    logic             at_max;

    always_comb begin
        at_max = &pos;
        pos_nx = pos + 1'b1;
        if (!bit_rise) begin
            launch = 1'b0;
        end else if (frame_mark) begin
            launch = (slot_start == '0);
        end else begin
            launch = synced && !at_max && (pos_nx == slot_start);
        end
    end

    // Position saturates so a long frame never launches a second slot
    always_ff @(posedge clk) begin
        if (rst) begin
            pos    <= '0;
            synced <= 1'b0;
        end else if (bit_rise) begin
            if (frame_mark) begin
                pos    <= '0;
                synced <= 1'b1;
            end else if (!at_max) begin
                pos <= pos_nx;
            end
        end
    end
endmodule

// File: rtl/pcm_slot_shift.sv
module pcm_slot_shift
    import pcm_slot_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_rise,
    input  logic      bit_fall,
    input  logic      launch,
    input  logic      tx_en,
    input  slot_ctx_t ctx,
    output logic      dx,
    output logic      dx_oe,
    output logic      tsc,
    output logic      tsc_oe
);
    logic [LIN_W-1:0] shreg;
    logic [LEN_W-1:0] rem;
    logic             active;
    logic             adj_q;
    logic             en_q;
    logic             oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            rem    <= '0;
            active <= 1'b0;
            adj_q  <= 1'b0;
            en_q   <= 1'b0;
            oe_q   <= 1'b0;
        end else if (bit_rise) begin
            en_q <= tx_en;
            if (!tx_en) begin
                active <= 1'b0;
                oe_q   <= 1'b0;
                rem    <= '0;
            end else if (launch) begin
                shreg  <= align_word(ctx.word, ctx.fmt);
                rem    <= slot_len(ctx.fmt);
                adj_q  <= ctx.adj;
                active <= 1'b1;
                oe_q   <= 1'b1;
            end else if (active && rem > LEN_W'(1)) begin
                shreg <= shreg << 1;
                rem   <= rem - 1'b1;
                oe_q  <= 1'b1;
            end else begin
                active <= 1'b0;
                oe_q   <= 1'b0;
                rem    <= '0;
            end
        end else if (bit_fall && active && adj_q && rem == LEN_W'(1)) begin
            oe_q <= 1'b0;
        end
    end

    assign dx     = shreg[LIN_W-1];
    assign dx_oe  = oe_q;
    assign tsc    = active;
    assign tsc_oe = en_q;
endmodule

// File: rtl/pcm_slot_tx.sv
module pcm_slot_tx
    import pcm_slot_tx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bclk,
    input  logic             fsync,
    input  logic [LIN_W-1:0] sample_in,
    input  logic [CNT_W-1:0] slot_start,
    input  logic             tx_en,
    input  logic             lin_mode,
    input  logic             adj_mode,
    input  logic             law_sel,
    output logic             dx,
    output logic             dx_oe,
    output logic             tsc,
    output logic             tsc_oe,
    output logic             law_flag
);
    logic             bit_rise;
    logic             bit_fall;
    logic             frame_mark;
    logic             launch;
    logic [LIN_W-1:0] smp_q;
    logic             law_q;
    slot_ctx_t        ctx;

    pcm_bclk_edge u_edge (
        .clk        (clk),
        .rst        (rst),
        .bclk       (bclk),
        .fsync      (fsync),
        .bit_rise   (bit_rise),
        .bit_fall   (bit_fall),
        .frame_mark (frame_mark)
    );

    pcm_frame_pos #(.CNT_W(CNT_W)) u_pos (
        .clk        (clk),
        .rst        (rst),
        .bit_rise   (bit_rise),
        .frame_mark (frame_mark),
        .slot_start (slot_start),
        .launch     (launch)
    );

    // Sample and law label are held from one frame sync to the next
    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= '0;
            law_q <= 1'b0;
        end else if (frame_mark) begin
            smp_q <= sample_in;
            law_q <= law_sel;
        end
    end

    always_comb begin
        ctx.word = frame_mark ? sample_in : smp_q;
        ctx.fmt  = fmt_e'(lin_mode);
        ctx.adj  = adj_mode;
    end

    pcm_slot_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .bit_rise (bit_rise),
        .bit_fall (bit_fall),
        .launch   (launch),
        .tx_en    (tx_en),
        .ctx      (ctx),
        .dx       (dx),
        .dx_oe    (dx_oe),
        .tsc      (tsc),
        .tsc_oe   (tsc_oe)
    );

    assign law_flag = law_q;
endmodule

// File: rtl/pcm_slot_tx_chk.sv
module pcm_slot_tx_chk (
    input logic clk,
    input logic rst,
    input logic bclk,
    input logic tx_en,
    input logic dx,
    input logic dx_oe,
    input logic tsc,
    input logic tsc_oe
);
    logic bclk_d;
    logic rise_now;
    logic rise_seen;

    assign rise_now = bclk & ~bclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_d    <= 1'b0;
            rise_seen <= 1'b0;
        end else begin
            bclk_d    <= bclk;
            rise_seen <= rise_now;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dx_oe && !tsc && !tsc_oe));

    assert_gated_by_enable_R2: assert property (@(posedge clk) disable iff (rst)
        !tsc_oe |-> (!dx_oe && !tsc));

    assert_oe_rises_on_bit_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(dx_oe)) |-> rise_seen);

    assert_strobe_on_bit_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !rise_seen) |-> $stable(tsc));

    assert_data_on_bit_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !rise_seen) |-> $stable(dx));

    assert_abort_on_disable_R9: assert property (@(posedge clk) disable iff (rst)
        (rise_now && !tx_en) |=> (!dx_oe && !tsc && !tsc_oe));
endmodule

bind pcm_slot_tx pcm_slot_tx_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .bclk   (bclk),
    .tx_en  (tx_en),
    .dx     (dx),
    .dx_oe  (dx_oe),
    .tsc    (tsc),
    .tsc_oe (tsc_oe)
);

// File: tb/pcm_slot_tx_tb.sv
module pcm_slot_tx_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0;
    logic        fsync = 1'b0;
    logic [15:0] sample_in = '0;
    logic [7:0]  slot_start = '0;
    logic        tx_en = 1'b0;
    logic        lin_mode = 1'b0;
    logic        adj_mode = 1'b0;
    logic        law_sel = 1'b0;
    logic        dx, dx_oe, tsc, tsc_oe, law_flag;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  oe1;
        logic  oe2;
        logic  bitv;
        logic  strobe;
        logic  soe;
        logic  law;
        string req;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    pcm_slot_tx u_dut (
        .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync),
        .sample_in(sample_in), .slot_start(slot_start), .tx_en(tx_en),
        .lin_mode(lin_mode), .adj_mode(adj_mode), .law_sel(law_sel),
        .dx(dx), .dx_oe(dx_oe), .tsc(tsc), .tsc_oe(tsc_oe), .law_flag(law_flag)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One bit period: rise, check mid first half, fall, check mid second half
    task automatic run_bit(input logic fs, input logic en);
        exp_t e;
        bclk = 1'b1; fsync = fs; tx_en = en;
        repeat (2) @(negedge clk);
        e = sb.pop_front();
        chk(dx_oe === e.oe1, e.req, "dx_oe first half", int'(dx_oe), int'(e.oe1));
        chk(tsc === e.strobe, e.req, "tsc", int'(tsc), int'(e.strobe));
        chk(tsc_oe === e.soe, e.req, "tsc_oe", int'(tsc_oe), int'(e.soe));
        chk(law_flag === e.law, e.req, "law_flag", int'(law_flag), int'(e.law));
        if (e.oe1) chk(dx === e.bitv, e.req, "dx bit", int'(dx), int'(e.bitv));
        repeat (2) @(negedge clk);
        bclk = 1'b0;
        repeat (2) @(negedge clk);
        chk(dx_oe === e.oe2, e.req, "dx_oe second half", int'(dx_oe), int'(e.oe2));
        repeat (2) @(negedge clk);
    endtask

    // Driver: computes the expected frame into the scoreboard, then plays it
    task automatic run_frame(input logic [15:0] word, input logic lin, input logic adj,
                             input int start, input int nbits, input logic en,
                             input int dis_at, input logic has_fs, input logic law,
                             input logic law_prev, input string req);
        logic [15:0] wv;
        int len;
        len = lin ? 16 : 8;
        wv  = lin ? word : {word[7:0], 8'h00};
        for (int k = 0; k < nbits; k++) begin
            exp_t e;
            logic en_k, in_slot;
            en_k    = en && (k < dis_at);
            in_slot = has_fs && en_k && (k >= start) && (k < start + len);
            e.oe1    = in_slot;
            e.oe2    = in_slot && !(adj && (k == start + len - 1));
            e.bitv   = in_slot ? wv[15 - (k - start)] : 1'b0;
            e.strobe = in_slot;
            e.soe    = en_k;
            e.law    = has_fs ? law : law_prev;
            e.req    = req;
            sb.push_back(e);
        end
        sample_in = word; lin_mode = lin; adj_mode = adj;
        slot_start = 8'(start); law_sel = law;
        for (int k = 0; k < nbits; k++) begin
            run_bit(has_fs && (k == 0), en && (k < dis_at));
            if (k == 0) begin
                sample_in = ~word;
                law_sel   = ~law;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(dx_oe === 1'b0, "R1", "dx_oe after reset", int'(dx_oe), 0);
        chk(tsc_oe === 1'b0, "R1", "tsc_oe after reset", int'(tsc_oe), 0);
        chk(tsc === 1'b0, "R1", "tsc after reset", int'(tsc), 0);
        // R10: enabled, no frame sync yet
        run_frame(16'h00FF, 1'b0, 1'b0, 3, 14, 1'b1, 999, 1'b0, 1'b0, 1'b0, "R10");
        // R2: frame sync with enable low, nothing driven
        run_frame(16'h00A5, 1'b0, 1'b0, 2, 12, 1'b0, 999, 1'b1, 1'b0, 1'b0, "R2");
        // R3 R5 R7 R8: 8-bit, normal mode, sample changed after frame sync
        run_frame(16'h12A5, 1'b0, 1'b0, 2, 12, 1'b1, 999, 1'b1, 1'b1, 1'b0, "R3_R8");
        // R5 R7: 16-bit linear at slot start 0
        run_frame(16'hC3A1, 1'b1, 1'b0, 0, 18, 1'b1, 999, 1'b1, 1'b0, 1'b1, "R5_R7");
        // R4: adjacent mode, 8-bit
        run_frame(16'h005B, 1'b0, 1'b1, 3, 13, 1'b1, 999, 1'b1, 1'b1, 1'b0, "R4");
        // R4: adjacent mode, 16-bit, frame ends on the last bit
        run_frame(16'h8001, 1'b1, 1'b1, 1, 17, 1'b1, 999, 1'b1, 1'b0, 1'b1, "R4_lin");
        // R9: enable dropped three bits into the slot
        run_frame(16'h00F0, 1'b0, 1'b0, 2, 12, 1'b1, 5, 1'b1, 1'b1, 1'b0, "R9");
        // R6 R8: later slot start, law flag back to 0
        run_frame(16'h0069, 1'b0, 1'b0, 10, 20, 1'b1, 999, 1'b1, 1'b0, 1'b1, "R6_R8");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule